// File: doc/BRIEF.md
# GPIO Port with Write-One Set/Clear Control

A memory-mapped general-purpose I/O port for up to 32 pins. Software changes a pin's output enable or driven level by writing a 1 to that pin's bit in a dedicated set register or a dedicated clear register. Bits written as 0 leave their pins alone. Several agents can therefore steer different pins without a read-modify-write sequence. A build-time valid mask names the pins that software may change at all.

Every pad input passes through a two-flop synchronizer. A read-only data-in register reports the synchronized pad level. For a pin configured as an output, it reports the driven level instead. Two plain read/write enable registers, one for rising and one for falling transitions, select which synchronized transitions produce a one-cycle event pulse on that pin's bit of the event vector. A separate interrupt cause block consumes that vector.

The register bus is a single 32-bit request with a write strobe and a 6-bit byte address. Read data is combinational in the request cycle. A write takes effect at the clock edge that ends the request cycle.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, all output enables, data-out bits, rise enables and fall enables are 0. Every register reads 0, `pad_oe` is 0 and `edge_evt` is 0.
- R2: A write to address 0x10 (output-enable set) sets the output enable of every pin whose write-data bit is 1 and whose valid-mask bit is 1. Pins whose write bit is 0 keep their output enable.
- R3: A write to address 0x20 (output-enable clear) clears the output enable of every pin whose write-data bit is 1 and whose valid-mask bit is 1. Other pins keep theirs.
- R4: Writes to address 0x14 (data-out set) and address 0x24 (data-out clear) set and clear data-out bits with the same write-one rules. `pad_out` shows the data-out bits from the following cycle.
- R5: Pins whose valid-mask bit is 0 are never changed by any set or clear write.
- R6: Address 0x00 (rise enable) and address 0x04 (fall enable) are plain read/write registers, one bit per pin, for every pin. A pin may have either, neither or both enabled.
- R7: Reading address 0x08 returns, for each pin, its data-out bit if its output enable is 1. Otherwise it returns the pad level after two synchronizer flops, so a pad change applied in the cycle ending at edge k appears in reads after edge k+1.
- R8: Reading address 0x10 or 0x20 returns the current output-enable vector. Reading address 0x14 or 0x24 returns the current data-out vector.
- R9: A 0-to-1 change between the last two synchronized samples of a pin with its rise enable set makes `edge_evt` for that pin 1 for exactly one cycle. A pad rise applied in the cycle ending at edge k shows between edges k+1 and k+2. Without the rise enable, no event is produced.
- R10: A 1-to-0 change between the last two synchronized samples of a pin with its fall enable set produces the same one-cycle event. With both enables set, either direction produces one.
- R11: Writes to address 0x08 or to any unlisted address change nothing. Reads of unlisted addresses return 0, and `bus_rdata` is 0 in any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Driven data-out levels |
| pad_oe | output | NUM_PINS | Per-pin output drive enable |
| edge_evt | output | NUM_PINS | One-cycle edge event per pin |

## Verification
The main function is driven three ways. Directed set and clear writes use overlapping and disjoint bit patterns, including bits outside the valid mask, which separates write-one semantics from plain overwrites and from mask leaks. Directed single-pin pad transitions on pins that have only rise, only fall, or both enables set separate the two edge qualifiers and pin the two-cycle latency. A long run of random pad levels, mixed with random set/clear writes and reads, shows that the event pulses and the data-in multiplexing between pad and driven level agree with the reference model in every cycle.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 6;

   localparam logic [ADDR_W-1:0] A_RISE_EN = 6'h00;
   localparam logic [ADDR_W-1:0] A_FALL_EN = 6'h04;
   localparam logic [ADDR_W-1:0] A_DIN     = 6'h08;
   localparam logic [ADDR_W-1:0] A_OE_SET  = 6'h10;
   localparam logic [ADDR_W-1:0] A_DO_SET  = 6'h14;
   localparam logic [ADDR_W-1:0] A_OE_CLR  = 6'h20;
   localparam logic [ADDR_W-1:0] A_DO_CLR  = 6'h24;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out,
   output logic [W-1:0] prev_out
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], async_in[i]};
      end
      assign sync_out[i] = chain[STAGES-1];
      assign prev_out[i] = chain[STAGES];
   end
endmodule

// File: rtl/gpio_sc_edge.sv
module gpio_sc_edge #(
   parameter int W = 32
) (
   input  logic [W-1:0] level,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   output logic [W-1:0] evt
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic went_up, went_down;
      assign went_up   =  level[i] & ~prev[i];
      assign went_down = ~level[i] &  prev[i];
      assign evt[i]    = (went_up & rise_en[i]) | (went_down & fall_en[i]);
   end
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
   import gpio_sc_pkg::*;
#(
   parameter int          W          = 32,
   parameter logic [31:0] VALID_MASK = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   input  logic [W-1:0]      pad_level,
   output logic [W-1:0]      oe_q,
   output logic [W-1:0]      dout_q,
   output logic [W-1:0]      rise_q,
   output logic [W-1:0]      fall_q,
   output logic [REG_W-1:0]  rdata
);
   localparam logic [W-1:0] WMASK = VALID_MASK[W-1:0];

   logic          wr, rd;
   logic [W-1:0]  wbits, mbits, din_view, rd_w;

   assign wr    = req &  we;
   assign rd    = req & ~we;
   assign wbits = wdata[W-1:0];
   assign mbits = wbits & WMASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= '0;
         dout_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (wr) begin
         unique case (addr)
            A_OE_SET:  oe_q   <= oe_q   |  mbits;
            A_OE_CLR:  oe_q   <= oe_q   & ~mbits;
            A_DO_SET:  dout_q <= dout_q |  mbits;
            A_DO_CLR:  dout_q <= dout_q & ~mbits;
            A_RISE_EN: rise_q <= wbits;
            A_FALL_EN: fall_q <= wbits;
            default: ;
         endcase
      end
   end

   assign din_view = (oe_q & dout_q) | (~oe_q & pad_level);

   always_comb begin
      rd_w = '0;
      if (rd) begin
         unique case (addr)
            A_RISE_EN:          rd_w = rise_q;
            A_FALL_EN:          rd_w = fall_q;
            A_DIN:              rd_w = din_view;
            A_OE_SET, A_OE_CLR: rd_w = oe_q;
            A_DO_SET, A_DO_CLR: rd_w = dout_q;
            default:            rd_w = '0;
         endcase
      end
   end

   if (W == REG_W) begin : g_full
      assign rdata = rd_w;
   end else begin : g_pad
      assign rdata = {{(REG_W-W){1'b0}}, rd_w};
   end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int          NUM_PINS    = 32,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] VALID_MASK  = 32'h0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] edge_evt
);
   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_pins
      $error("NUM_PINS must be within 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] lvl_s, prev_s, oe_q, dout_q, rise_q, fall_q;

   gpio_sc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in),
      .sync_out(lvl_s), .prev_out(prev_s)
   );

   gpio_sc_regs #(.W(NUM_PINS), .VALID_MASK(VALID_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we),
      .addr(bus_addr), .wdata(bus_wdata), .pad_level(lvl_s),
      .oe_q(oe_q), .dout_q(dout_q), .rise_q(rise_q), .fall_q(fall_q),
      .rdata(bus_rdata)
   );

   gpio_sc_edge #(.W(NUM_PINS)) u_edge (
      .level(lvl_s), .prev(prev_s), .rise_en(rise_q), .fall_en(fall_q),
      .evt(edge_evt)
   );

   assign pad_out = dout_q;
   assign pad_oe  = oe_q;
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
   parameter int          W          = 32,
   parameter logic [31:0] VALID_MASK = 32'h0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_req,
   input logic         bus_we,
   input logic [5:0]   bus_addr,
   input logic [31:0]  bus_wdata,
   input logic [31:0]  bus_rdata,
   input logic [W-1:0] pad_out,
   input logic [W-1:0] pad_oe,
   input logic [W-1:0] edge_evt,
   input logic [W-1:0] rise_q,
   input logic [W-1:0] fall_q
);
   localparam logic [W-1:0] M = VALID_MASK[W-1:0];

   AST_OE_SET_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == 6'h10) |=>
      ((pad_oe & $past(bus_wdata[W-1:0]) & M) == ($past(bus_wdata[W-1:0]) & M))); // R2

   AST_OE_CLR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == 6'h20) |=>
      ((pad_oe & $past(bus_wdata[W-1:0]) & M) == '0)); // R3

   AST_DO_CLR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == 6'h24) |=>
      ((pad_out & $past(bus_wdata[W-1:0]) & M) == '0)); // R4

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pad_oe & ~M) && $stable(pad_out & ~M)); // R5

   AST_DIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_addr == 6'h08) |->
      ((bus_rdata[W-1:0] & pad_oe) == (pad_out & pad_oe))); // R7

   AST_EVT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt & ~(rise_q | fall_q)) == '0); // R9

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |-> bus_rdata == '0); // R11
endmodule

bind gpio_setclr_port gpio_sc_chk #(.W(NUM_PINS), .VALID_MASK(VALID_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_out(pad_out), .pad_oe(pad_oe), .edge_evt(edge_evt),
   .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/sim_gpio_setclr_port.sv
`timescale 1ns/1ps
module sim_gpio_setclr_port;
   localparam logic [31:0] VM = 32'hF0FF_FFF3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] pad_in = '0, pad_out, pad_oe, edge_evt;

   int n_chk = 0, n_fail = 0;

   // behavioural reference state
   bit [31:0] m_oe, m_do, m_rise, m_fall;
   bit [31:0] hist[$];   // pad samples, newest first

   always #2 clk = ~clk;

   gpio_setclr_port #(.NUM_PINS(32), .SYNC_STAGES(2), .VALID_MASK(VM)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .edge_evt(edge_evt)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit [31:0] m_level();
      return hist[1];
   endfunction

   function automatic bit [31:0] m_evt();
      bit [31:0] a = hist[1], b = hist[2];
      return (a & ~b & m_rise) | (~a & b & m_fall);
   endfunction

   function automatic bit [31:0] m_read(bit [5:0] a);
      case (a)
         6'h00: return m_rise;
         6'h04: return m_fall;
         6'h08: return (m_oe & m_do) | (~m_oe & m_level());
         6'h10, 6'h20: return m_oe;
         6'h14, 6'h24: return m_do;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_reset();
      m_oe = 0; m_do = 0; m_rise = 0; m_fall = 0;
      hist = '{32'h0, 32'h0, 32'h0};
   endtask

   // one bus cycle; inputs applied at the falling edge
   task automatic cyc(bit rq, bit w, bit [5:0] a, bit [31:0] d, bit [31:0] pad, string tag);
      bus_req = rq; bus_we = w; bus_addr = a; bus_wdata = d; pad_in = pad;
      #1;
      if (rq && !w) chk({tag, " read"}, bus_rdata, m_read(a));
      else          chk("R11 idle rdata", bus_rdata, 32'h0);
      @(posedge clk);
      if (rq && w) begin
         case (a)
            6'h10: m_oe = m_oe | (d & VM);
            6'h20: m_oe = m_oe & ~(d & VM);
            6'h14: m_do = m_do | (d & VM);
            6'h24: m_do = m_do & ~(d & VM);
            6'h00: m_rise = d;
            6'h04: m_fall = d;
            default: ;
         endcase
      end
      hist.push_front(pad);
      void'(hist.pop_back());
      @(negedge clk);
      chk("R2 R3 pad_oe", pad_oe, m_oe);
      chk("R4 pad_out", pad_out, m_do);
      chk("R9 R10 edge_evt", edge_evt, m_evt());
   endtask

   task automatic wr(bit [5:0] a, bit [31:0] d, string tag);
      cyc(1, 1, a, d, pad_in, tag);
   endtask
   task automatic rd(bit [5:0] a, string tag);
      cyc(1, 0, a, 0, pad_in, tag);
   endtask
   task automatic idle(bit [31:0] pad);
      cyc(0, 0, 0, 0, pad, "idle");
   endtask

   initial begin
      #150000;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 pad_oe", pad_oe, 32'h0);
      chk("R1 edge_evt", edge_evt, 32'h0);
      rd(6'h00, "R1"); rd(6'h04, "R1"); rd(6'h10, "R1"); rd(6'h14, "R1");
      // R2 R5: set with masked-out bits
      wr(6'h10, 32'h0000_00FF, "R2");
      rd(6'h10, "R2 R8");
      chk("R5 oe masked", pad_oe, 32'h0000_00F3);
      wr(6'h10, 32'h0F00_0000, "R5");
      chk("R5 oe untouched", pad_oe, 32'h0000_00F3);
      // R4: data out set/clear
      wr(6'h14, 32'hFFFF_FFFF, "R4");
      chk("R4 dout set", pad_out, VM);
      wr(6'h24, 32'h0000_00F0, "R4");
      chk("R4 dout clr", pad_out, VM & ~32'hF0);
      rd(6'h24, "R8");
      // R3
      wr(6'h20, 32'h0000_0030, "R3");
      chk("R3 oe clr", pad_oe, 32'h0000_00C3);
      rd(6'h20, "R8");
      // R11: read-only and unmapped
      wr(6'h08, 32'hFFFF_FFFF, "R11");
      wr(6'h30, 32'hFFFF_FFFF, "R11");
      chk("R11 oe after junk", pad_oe, 32'h0000_00C3);
      rd(6'h30, "R11");
      rd(6'h0C, "R11");
      // R6: enables
      wr(6'h00, 32'h0000_FF00, "R6");
      wr(6'h04, 32'h00FF_FF00, "R6");
      rd(6'h00, "R6"); rd(6'h04, "R6");
      // R7 R9 R10: directed edges
      idle(32'h0000_0100);              // pin 8 rise (both enabled)
      idle(32'h0001_0100);              // pin 16 rise (fall only)
      chk("R9 pin8 rise evt", edge_evt, 32'h0000_0100);
      rd(6'h08, "R7");
      idle(32'h0001_0100);
      idle(32'h0001_0000);              // pin 16 fall later, pin 8 fall
      idle(32'h0000_0000);
      chk("R10 pin8 fall evt", edge_evt, 32'h0000_0100);
      idle(32'h0000_0000);
      chk("R10 pin16 fall evt", edge_evt, 32'h0001_0000);
      idle(32'h0080_0000);              // pin 23 rise, fall only -> none
      idle(32'h0080_0000);
      idle(32'h0080_0000);
      rd(6'h08, "R7");
      // random mix, model compared every cycle
      for (int i = 0; i < 400; i++) begin
         bit [31:0] p = $urandom;
         int k = $urandom_range(0, 9);
         bit [5:0] a;
         case ($urandom_range(0, 6))
            0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h08; 3: a = 6'h10;
            4: a = 6'h14; 5: a = 6'h20; default: a = 6'h24;
         endcase
         if (k < 3)      cyc(1, 1, a, $urandom, p, "R6 R2");
         else if (k < 7) cyc(1, 0, a, 0, p, "R7 R8");
         else            cyc(0, 0, 0, 0, p, "R9");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule